// File: doc/BRIEF.md
# Synchronous Burst SRAM with Byte-Lane Writes

This block is an on-chip synchronous static RAM with a burst address generator. The data word is split into byte lanes, four by default. A bus master loads a start address with one of two load strobes. The CPU-side strobe is qualified by the master select. The controller-side strobe loads whenever it is low. After a load, an advance input steps through a four-beat burst. The two low address bits follow an interleaved (XOR) order or a linear order that wraps modulo 4.

Three levels of write control are decoded on every beat:
- An all-lanes write strobe.
- A byte-write gate.
- One strobe per lane.

Each beat is therefore either a read or a write of a chosen set of lanes. Read data leaves through one register stage (flow-through) or two (pipelined), chosen by a static pin. The output is driven only while the asynchronous output enable is low and read data is present. Everything except output enable, flow select and order select is sampled on the rising clock edge.

The data paths are plain pins, with no valid/ready handshake. The array accepts a beat on every clock, so there is no back-pressure. The drive flag `dout_en` plays the role of an output-valid signal that the consumer must sample.

Top module: `sbsram`

## Requirements
- R1: After reset the block is in standby: `dout_en` is 0 and `dout` is 0, even with `oe_n` low.
- R2: A load happens on an edge where `ld_cpu_n` is low and `cs_n` is low, or where `ld_ctl_n` is low. While `cs_n` is high, `ld_cpu_n` is ignored and a burst in progress continues unchanged.
- R3: On a load edge the block is selected only if `cs_n`=0, `cs_hi`=1 and `cs_lo_n`=0. Otherwise it enters standby: later beats neither write the array nor drive `dout` until the next selecting load.
- R4: On an edge with no load and the block selected, `adv_n`=0 moves to the next burst beat and `adv_n`=1 repeats the current address. A load on the same edge takes precedence over the advance and restarts at beat 0.
- R5: With `ord_xor`=1, beat k (k=0..3) uses low address bits equal to start[1:0] XOR k, with the upper bits unchanged.
- R6: With `ord_xor`=0, beat k uses low address bits equal to (start[1:0]+k) mod 4, with the upper bits unchanged.
- R7: With `wr_all_n`=0, a write beat writes all lanes, whatever `wr_byte_n` and `wr_lane_n` are.
- R8: With `wr_all_n`=1 and `wr_byte_n`=0, lane i (bits 8i+7..8i) is written only when `wr_lane_n[i]`=0. If no bit of `wr_lane_n` is 0, the beat is a read.
- R9: With `wr_all_n`=1 and `wr_byte_n`=1, the beat is a read.
- R10: A beat loaded by `ld_cpu_n` is always a read. A beat loaded by `ld_ctl_n`, and every later burst beat, follows R7 to R9.
- R11: `dout_en` = (`oe_n`=0) AND (the selected output stage holds read data). `oe_n` acts without a clock, and `dout` is 0 whenever `dout_en` is 0.
- R12: With `flow_n`=0, read data for a beat appears after the next rising edge. With `flow_n`=1 it appears one edge later.
- R13: Write data is captured on the edge of its beat. A later read of that address returns the merged lanes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of control state |
| addr | input | AW | Load address |
| din | input | 8*LANES | Write data |
| cs_n | input | 1 | Master select, active low |
| cs_hi | input | 1 | Secondary select, active high |
| cs_lo_n | input | 1 | Secondary select, active low |
| ld_cpu_n | input | 1 | CPU-side load strobe, qualified by `cs_n` |
| ld_ctl_n | input | 1 | Controller-side load strobe |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | All-lanes write, active low |
| wr_byte_n | input | 1 | Byte-write gate, active low |
| wr_lane_n | input | LANES | Per-lane write strobes, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| flow_n | input | 1 | 0 = flow-through reads, 1 = pipelined reads |
| ord_xor | input | 1 | 1 = interleaved burst order, 0 = linear |
| dout | output | 8*LANES | Read data, 0 when not driven |
| dout_en | output | 1 | Read data is being driven |

## Verification
Two functions can fall in the same clock cycle. A new load (controller strobe) can arrive on the edge where `adv_n` is low. An output-enable change can also arrive while an earlier pipelined read is still in the second stage. The bench makes both happen with directed cases and with a random phase that draws the strobes, the advance input and `oe_n` independently. A reference model in the bench predicts the winning address and the driven word. Output enable is toggled between clock edges and judged straight away, without waiting for an edge.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  localparam int LANE_W = 8;
  localparam int CNT_W  = 2;

  // Low address bits for burst beat `beat` starting from `start`.
  function automatic logic [CNT_W-1:0] burst_lo(input logic [CNT_W-1:0] start,
                                                input logic [CNT_W-1:0] beat,
                                                input logic             use_xor);
    logic [CNT_W-1:0] res;
    if (use_xor) res = start ^ beat;
    else         res = start + beat;
    return res;
  endfunction
endpackage

// File: rtl/sbsram_addr_ctrl.sv
module sbsram_addr_ctrl
  import sbsram_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          cs_n,
  input  logic          cs_hi,
  input  logic          cs_lo_n,
  input  logic          ld_cpu_n,
  input  logic          ld_ctl_n,
  input  logic          adv_n,
  input  logic          ord_xor,
  output logic [AW-1:0] beat_addr,
  output logic          beat_act,
  output logic          beat_cpu,
  output logic [AW-1:0] base_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic          active_q
);
  logic             load_cpu, load_ctl, load, sel;
  logic [CNT_W-1:0] cnt_nxt;
  logic [AW-1:0]    origin;

  always_comb begin
    load_cpu = !ld_cpu_n && !cs_n;
    load_ctl = !ld_ctl_n && !load_cpu;
    load     = load_cpu || load_ctl;
    sel      = !cs_n && cs_hi && !cs_lo_n;
    origin   = load ? addr : base_q;
    if (load)                    cnt_nxt = '0;
    else if (active_q && !adv_n) cnt_nxt = cnt_q + 1'b1;
    else                         cnt_nxt = cnt_q;
    beat_addr = {origin[AW-1:CNT_W], burst_lo(origin[CNT_W-1:0], cnt_nxt, ord_xor)};
    beat_act  = load ? sel : active_q;
    beat_cpu  = load_cpu;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      cnt_q    <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      base_q   <= addr;
      cnt_q    <= '0;
      active_q <= sel;
    end else begin
      cnt_q    <= cnt_nxt;
    end
  end
endmodule

// File: rtl/sbsram_wr_decode.sv
module sbsram_wr_decode #(
  parameter int LANES = 4
) (
  input  logic             beat_act,
  input  logic             beat_cpu,
  input  logic             wr_all_n,
  input  logic             wr_byte_n,
  input  logic [LANES-1:0] wr_lane_n,
  output logic [LANES-1:0] lane_we,
  output logic             rd_beat
);
  logic [LANES-1:0] lane_req;

  always_comb begin
    if (!wr_all_n)       lane_req = '1;
    else if (!wr_byte_n) lane_req = ~wr_lane_n;
    else                 lane_req = '0;
    lane_we = (beat_act && !beat_cpu) ? lane_req : '0;
    rd_beat = beat_act && (beat_cpu || (lane_req == '0));
  end
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array
  import sbsram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic [LANES-1:0]        lane_we,
  input  logic                    rd_en,
  output logic [LANES*LANE_W-1:0] rd_q,
  output logic                    rd_vld
);
  localparam int DEPTH = 1 << AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];
    logic [LANE_W-1:0] lane_rd;
    always_ff @(posedge clk) begin
      if (lane_we[g]) lane_mem[addr] <= din[g*LANE_W +: LANE_W];
      if (rd_en)      lane_rd        <= lane_mem[addr];
    end
    assign rd_q[g*LANE_W +: LANE_W] = lane_rd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_vld <= 1'b0;
    else        rd_vld <= rd_en;
  end
endmodule

// File: rtl/sbsram_out_stage.sv
module sbsram_out_stage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] s1_d,
  input  logic         s1_v,
  input  logic         flow_n,
  input  logic         oe_n,
  output logic [W-1:0] dout,
  output logic         dout_en,
  output logic         s2_v
);
  logic [W-1:0] s2_d;

  always_ff @(posedge clk) s2_d <= s1_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s2_v <= 1'b0;
    else        s2_v <= s1_v;
  end

  always_comb begin
    dout_en = !oe_n && (flow_n ? s2_v : s1_v);
    dout    = dout_en ? (flow_n ? s2_d : s1_d) : '0;
  end
endmodule

// File: rtl/sbsram.sv
module sbsram
  import sbsram_pkg::*;
#(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           addr,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic                    cs_n,
  input  logic                    cs_hi,
  input  logic                    cs_lo_n,
  input  logic                    ld_cpu_n,
  input  logic                    ld_ctl_n,
  input  logic                    adv_n,
  input  logic                    wr_all_n,
  input  logic                    wr_byte_n,
  input  logic [LANES-1:0]        wr_lane_n,
  input  logic                    oe_n,
  input  logic                    flow_n,
  input  logic                    ord_xor,
  output logic [LANES*LANE_W-1:0] dout,
  output logic                    dout_en
);
  localparam int W = LANES * LANE_W;

  logic [AW-1:0]    beat_addr, base_q;
  logic [CNT_W-1:0] cnt_q;
  logic             beat_act, beat_cpu, active_q;
  logic [LANES-1:0] lane_we;
  logic             rd_beat, s1_v, s2_v;
  logic [W-1:0]     s1_d;

  sbsram_addr_ctrl #(.AW(AW)) u_ctrl (
    .clk, .rst_n, .addr, .cs_n, .cs_hi, .cs_lo_n, .ld_cpu_n, .ld_ctl_n,
    .adv_n, .ord_xor, .beat_addr, .beat_act, .beat_cpu,
    .base_q, .cnt_q, .active_q
  );

  sbsram_wr_decode #(.LANES(LANES)) u_dec (
    .beat_act, .beat_cpu, .wr_all_n, .wr_byte_n, .wr_lane_n,
    .lane_we, .rd_beat
  );

  sbsram_array #(.AW(AW), .LANES(LANES)) u_mem (
    .clk, .rst_n, .addr(beat_addr), .din, .lane_we, .rd_en(rd_beat),
    .rd_q(s1_d), .rd_vld(s1_v)
  );

  sbsram_out_stage #(.W(W)) u_out (
    .clk, .rst_n, .s1_d, .s1_v, .flow_n, .oe_n, .dout, .dout_en, .s2_v
  );
endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk #(
  parameter int AW    = 8,
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cs_n,
  input logic             cs_hi,
  input logic             cs_lo_n,
  input logic             ld_cpu_n,
  input logic             ld_ctl_n,
  input logic             adv_n,
  input logic             wr_all_n,
  input logic             oe_n,
  input logic             dout_en,
  input logic [LANES*8-1:0] dout,
  input logic [AW-1:0]    base_q,
  input logic [1:0]       cnt_q,
  input logic             active_q,
  input logic             beat_act,
  input logic [LANES-1:0] lane_we,
  input logic             rd_beat,
  input logic             s1_v
);
  logic any_load;
  assign any_load = !ld_ctl_n || (!ld_cpu_n && !cs_n);

  p_oe_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
    dout_en |-> !oe_n);
  p_quiet_out_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_en |-> dout == '0);
  p_cpu_blocked_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && ld_ctl_n) |=> ($stable(base_q) && $stable(active_q)));
  p_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (any_load && !(!cs_n && cs_hi && !cs_lo_n)) |=> !active_q);
  p_standby_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_q && !any_load) |-> lane_we == '0);
  p_adv_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_load && active_q && !adv_n) |=> cnt_q == $past(cnt_q) + 2'd1);
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_load && adv_n) |=> ($stable(cnt_q) && $stable(base_q)));
  p_load_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    any_load |=> cnt_q == 2'd0);
  p_all_lanes_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_act && !wr_all_n && !(!ld_cpu_n && !cs_n)) |-> lane_we == '1);
  p_cpu_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_cpu_n && !cs_n) |-> lane_we == '0);
  p_read_stage_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat |=> s1_v);
  p_one_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_beat |-> lane_we == '0);
endmodule

bind sbsram sbsram_chk #(.AW(AW), .LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .cs_hi(cs_hi), .cs_lo_n(cs_lo_n),
  .ld_cpu_n(ld_cpu_n), .ld_ctl_n(ld_ctl_n), .adv_n(adv_n), .wr_all_n(wr_all_n),
  .oe_n(oe_n), .dout_en(dout_en), .dout(dout), .base_q(base_q), .cnt_q(cnt_q),
  .active_q(active_q), .beat_act(beat_act), .lane_we(lane_we),
  .rd_beat(rd_beat), .s1_v(s1_v)
);

// File: tb/sbsram_bench.sv
module sbsram_bench;
  localparam int AW = 8, LANES = 4, W = 32;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [AW-1:0] addr;
  logic [W-1:0] din, dout;
  logic cs_n, cs_hi, cs_lo_n, ld_cpu_n, ld_ctl_n, adv_n;
  logic wr_all_n, wr_byte_n, oe_n, flow_n, ord_xor, dout_en;
  logic [LANES-1:0] wr_lane_n;

  sbsram #(.AW(AW), .LANES(LANES)) u_sbsram (.*);

  int errors = 0, checks = 0;

  // reference model state
  logic [W-1:0]  mm [256];
  logic [AW-1:0] m_base;
  logic [1:0]    m_cnt;
  bit            m_act, s1_v, s2_v;
  logic [W-1:0]  s1_d, s2_d;

  task automatic idle();
    addr = '0; din = '0; cs_n = 0; cs_hi = 1; cs_lo_n = 0;
    ld_cpu_n = 1; ld_ctl_n = 1; adv_n = 1;
    wr_all_n = 1; wr_byte_n = 1; wr_lane_n = 4'hF; oe_n = 0;
  endtask

  task automatic model_step();
    bit lp, lc, ld, sel, act, rd;
    logic [1:0] c, lo;
    logic [AW-1:0] o, a;
    logic [3:0] we;
    lp  = !ld_cpu_n && !cs_n;
    lc  = !ld_ctl_n && !lp;
    ld  = lp || lc;
    sel = !cs_n && cs_hi && !cs_lo_n;
    if (ld) c = 2'd0; else if (m_act && !adv_n) c = m_cnt + 2'd1; else c = m_cnt;
    o   = ld ? addr : m_base;
    lo  = ord_xor ? (o[1:0] ^ c) : (o[1:0] + c);
    a   = {o[AW-1:2], lo};
    act = ld ? sel : m_act;
    we  = !wr_all_n ? 4'hF : (!wr_byte_n ? ~wr_lane_n : 4'h0);
    rd  = act && (lp || we == 4'h0);
    if (!act || lp) we = 4'h0;
    s2_v = s1_v; s2_d = s1_d;
    if (rd) s1_d = mm[a];
    s1_v = rd;
    for (int i = 0; i < LANES; i++) if (we[i]) mm[a][8*i +: 8] = din[8*i +: 8];
    if (ld) begin m_base = addr; m_cnt = 2'd0; m_act = sel; end
    else m_cnt = c;
  endtask

  task automatic check(input string tag);
    bit exp_en;
    logic [W-1:0] exp_d;
    exp_en = !oe_n && (flow_n ? s2_v : s1_v);
    exp_d  = exp_en ? (flow_n ? s2_d : s1_d) : '0;
    checks++;
    if (dout_en !== exp_en || dout !== exp_d) begin
      errors++;
      $display("FAIL %s: dout_en=%b dout=%h expected dout_en=%b dout=%h",
               tag, dout_en, dout, exp_en, exp_d);
    end
  endtask

  task automatic tick(input string tag);
    model_step();
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic load_ctl(input logic [AW-1:0] a);
    idle(); ld_ctl_n = 0; addr = a;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle(); flow_n = 1; ord_xor = 1; rst_n = 0;
    m_base = '0; m_cnt = '0; m_act = 0; s1_v = 0; s2_v = 0; s1_d = '0; s2_d = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    check("R1");
    tick("R1");

    // prefill addresses 0..31 with all-lane writes through controller loads
    for (int a = 0; a < 32; a++) begin
      load_ctl(8'(a)); wr_all_n = 0; wr_byte_n = 0; wr_lane_n = 4'hF;
      din = $urandom;
      tick("R7");
    end

    // latency: pipelined then flow-through
    flow_n = 1; load_ctl(8'd5); tick("R12");
    idle(); tick("R12"); tick("R12");
    flow_n = 0; load_ctl(8'd6); tick("R12");
    idle(); tick("R12");

    // R11: output enable without clock
    oe_n = 1; #1 check("R11");
    oe_n = 0; #1 check("R11");

    // burst orders, including wrap past beat 3
    ord_xor = 1; load_ctl(8'd6); tick("R5");
    idle(); adv_n = 0; for (int k = 0; k < 4; k++) tick("R5");
    ord_xor = 0; load_ctl(8'd7); tick("R6");
    idle(); adv_n = 0; for (int k = 0; k < 4; k++) tick("R6");
    idle(); tick("R4");

    // R8 / R13: partial lane write then merged read-back
    load_ctl(8'd9); wr_byte_n = 0; wr_lane_n = 4'b1010; din = 32'hC3C3C3C3; tick("R8");
    idle(); wr_byte_n = 0; wr_lane_n = 4'hF; din = 32'h11111111; tick("R8");
    idle(); tick("R13");
    load_ctl(8'd9); tick("R13");
    flow_n = 1; idle(); tick("R13"); tick("R13");

    // R9: lane strobes low but both gates high
    idle(); wr_lane_n = 4'h0; din = 32'hDEADBEEF; tick("R9");
    idle(); tick("R9"); tick("R9");

    // R10: CPU load with all-lanes write requested is a read
    idle(); ld_cpu_n = 0; addr = 8'd12; wr_all_n = 0; din = 32'h0BADF00D; tick("R10");
    idle(); tick("R10");
    load_ctl(8'd12); tick("R10");
    idle(); tick("R10"); tick("R10");

    // R2: CPU strobe with master select high is ignored mid-burst
    ord_xor = 1; load_ctl(8'd16); tick("R2");
    idle(); cs_n = 1; ld_cpu_n = 0; addr = 8'd20; adv_n = 0; tick("R2");
    idle(); adv_n = 0; tick("R2"); tick("R2");

    // R3: deselecting load then standby writes ignored
    load_ctl(8'd3); cs_hi = 0; tick("R3");
    idle(); adv_n = 0; wr_all_n = 0; din = 32'hFFFF0000; tick("R3"); tick("R3");
    load_ctl(8'd24); cs_n = 1; tick("R3");
    idle(); wr_all_n = 0; tick("R3");
    load_ctl(8'd3); tick("R3");
    idle(); tick("R3"); tick("R3");

    // R4: load on the same edge as advance wins
    load_ctl(8'd17); tick("R4");
    idle(); adv_n = 0; tick("R4");
    load_ctl(8'd28); adv_n = 0; tick("R4");
    idle(); tick("R4"); tick("R4");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      addr      = 8'($urandom_range(0, 31));
      din       = $urandom;
      cs_n      = ($urandom_range(0, 9) < 2);
      cs_hi     = ($urandom_range(0, 9) != 0);
      cs_lo_n   = ($urandom_range(0, 9) == 0);
      ld_cpu_n  = ($urandom_range(0, 99) >= 15);
      ld_ctl_n  = ($urandom_range(0, 99) >= 15);
      adv_n     = ($urandom_range(0, 9) >= 6);
      wr_all_n  = ($urandom_range(0, 9) != 0);
      wr_byte_n = ($urandom_range(0, 9) >= 3);
      wr_lane_n = 4'($urandom);
      oe_n      = ($urandom_range(0, 9) < 2);
      if ($urandom_range(0, 49) == 0) flow_n  = ~flow_n;
      if ($urandom_range(0, 29) == 0) ord_xor = ~ord_xor;
      tick("R13");
      if ($urandom_range(0, 19) == 0) begin
        oe_n = ~oe_n; #1 check("R11");
      end
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule